// File: doc/BRIEF.md
# Warp Divergence and Reconvergence Stack

This block keeps the control state of one warp, a group of threads that share a single program counter. It holds a stack whose entries each carry a next PC, a reconvergence PC with its valid bit, and an active mask with one bit per thread. The top entry decides what the warp runs: the fetch side reads its next PC as `warpPc` and runs only the threads set in `warpMask`.

Two kinds of event move the warp forward. A step event moves the top entry to a new PC. A branch event supplies a per-thread taken vector, a taken target, a fall-through target and the reconvergence PC. The block judges the branch only on the active threads. If they all go the same way, the top entry is retargeted and nothing is pushed. If they split, the top entry is parked at the reconvergence PC. Then the fall-through path is pushed, and the taken path is pushed above it, so the taken path runs first. When the top entry's next PC reaches its own reconvergence PC, that entry is popped in a dedicated cycle. This brings back the path or the wider mask below it.

The stack depth is a parameter. A split that would not fit sets a sticky overflow flag and leaves the stack untouched.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the stack holds one entry: `warpPc` equals `START_PC`, `warpMask` is all ones, `stackDepth` is 1, `overflow` is 0 and `issueOk` is 1.
- R2: `warpPc` and `warpMask` always show the next PC and the active mask of the top entry. Bit i of every mask belongs to thread i.
- R3: When `issueOk` is 1 and a step event arrives (`stepValid`), `warpPc` equals `stepPc` from the next cycle. Mask and depth are unchanged.
- R4: A branch in which every active thread is taken moves `warpPc` to `brTakenPc`. A branch in which no active thread is taken moves it to `brFallPc`. Neither changes the depth or the mask.
- R5: A branch with both a taken and a not-taken active thread raises the depth by 2. From the next cycle the top shows `brTakenPc` with the mask `brTaken & warpMask`.
- R6: When the top entry's next PC equals its reconvergence PC, `issueOk` is 0 for one cycle and the entry is popped. After the taken path is popped, the fall-through path shows `brFallPc` with the mask `~brTaken & warpMask`. After that path is popped, the parked entry shows the reconvergence PC with the wider mask.
- R7: In a cycle where `issueOk` is 0, branch and step events are ignored. The only change is the pop.
- R8: When `brValid` and `stepValid` are both high, the branch is applied and the step is ignored.
- R9: A split attempted while `stackDepth` is greater than DEPTH-2 sets `overflow`. The PC, mask and depth stay as they were. `overflow` stays set until reset, and uniform branches keep working while the stack is full.
- R10: The bottom entry has no reconvergence PC and is never popped, whatever its PC.
- R11: Taken bits of threads that are inactive in the top mask have no effect on the outcome of a branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| brValid | input | 1 | Branch event this cycle |
| brTaken | input | THREADS | Per-thread taken vector |
| brTakenPc | input | PCW | Target of the taken path |
| brFallPc | input | PCW | Target of the not-taken path |
| brReconvPc | input | PCW | PC at which the paths rejoin |
| stepValid | input | 1 | Non-branch advance this cycle |
| stepPc | input | PCW | New PC for a step event |
| warpPc | output | PCW | PC the warp fetches |
| warpMask | output | THREADS | Threads that execute |
| issueOk | output | 1 | Low while a pop is in progress |
| stackDepth | output | $clog2(DEPTH+1) | Number of valid entries |
| overflow | output | 1 | Sticky flag for a refused split |

## Verification
A branch or step event can arrive in the same cycle that the top entry reaches its reconvergence PC, so a pop and an event compete for one cycle. The bench provokes this by stepping a taken path onto its reconvergence PC, then presenting a divergent branch and a step together while `issueOk` is low. It then requires that only the pop took effect: the fall-through PC and mask appear, and the depth has dropped by one. Branch and step are also raised together in a normal cycle, where the branch target must win. Every 4-bit taken vector is swept from a full mask, and both paths are walked back to reconvergence.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;

  // One-hot-ish command from control to the stack storage.
  typedef struct packed {
    logic pop;       // drop the top entry
    logic split;     // park top at reconv PC and push fall then taken
    logic retarget;  // rewrite the top entry's next PC
    logic ovfSet;    // refused split, set sticky flag
  } stackCmd_t;

endpackage

// File: rtl/simt_stack_ctrl.sv
module simt_stack_ctrl
  import simt_stack_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int DEPTH   = 8,
  parameter int PCW     = 16,
  localparam int DW     = $clog2(DEPTH + 1)
) (
  input  logic               brValid,
  input  logic [THREADS-1:0] brTaken,
  input  logic [PCW-1:0]     brTakenPc,
  input  logic [PCW-1:0]     brFallPc,
  input  logic [PCW-1:0]     brReconvPc,
  input  logic               stepValid,
  input  logic [PCW-1:0]     stepPc,
  input  logic [PCW-1:0]     topNext,
  input  logic [PCW-1:0]     topRc,
  input  logic               topRcValid,
  input  logic [THREADS-1:0] topMask,
  input  logic [DW-1:0]      depth,
  output stackCmd_t          cmd,
  output logic [PCW-1:0]     newNext,
  output logic [THREADS-1:0] takenSub,
  output logic [THREADS-1:0] fallSub,
  output logic               issueOk
);

  logic noRoom;
  assign noRoom = int'(depth) > (DEPTH - 2);

  always_comb begin
    cmd      = '0;
    newNext  = topNext;
    issueOk  = 1'b1;
    takenSub = brTaken & topMask;
    fallSub  = ~brTaken & topMask;
    if (topRcValid && (topNext == topRc)) begin
      cmd.pop = 1'b1;
      issueOk = 1'b0;
    end else if (brValid) begin
      if ((|takenSub) && (|fallSub)) begin
        if (noRoom) begin
          cmd.ovfSet = 1'b1;
        end else begin
          cmd.split = 1'b1;
          newNext   = brReconvPc;
        end
      end else begin
        cmd.retarget = 1'b1;
        newNext      = (|takenSub) ? brTakenPc : brFallPc;
      end
    end else if (stepValid) begin
      cmd.retarget = 1'b1;
      newNext      = stepPc;
    end
  end

endmodule

// File: rtl/simt_stack_dp.sv
module simt_stack_dp
  import simt_stack_pkg::*;
#(
  parameter int             THREADS  = 4,
  parameter int             DEPTH    = 8,
  parameter int             PCW      = 16,
  parameter logic [PCW-1:0] START_PC = '0,
  localparam int            DW       = $clog2(DEPTH + 1),
  localparam int            IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  stackCmd_t          cmd,
  input  logic [PCW-1:0]     newNext,
  input  logic [PCW-1:0]     takenPc,
  input  logic [PCW-1:0]     fallPc,
  input  logic [PCW-1:0]     rcPc,
  input  logic [THREADS-1:0] takenSub,
  input  logic [THREADS-1:0] fallSub,
  output logic [PCW-1:0]     topNext,
  output logic [PCW-1:0]     topRc,
  output logic               topRcValid,
  output logic [THREADS-1:0] topMask,
  output logic [DW-1:0]      depth,
  output logic               overflow
);

  logic [PCW-1:0]     nextMem [DEPTH];
  logic [PCW-1:0]     rcMem   [DEPTH];
  logic [THREADS-1:0] maskMem [DEPTH];
  logic [DEPTH-1:0]   rcvBits;
  logic [IW-1:0]      topIdx;

  assign topIdx     = IW'(depth - DW'(1));
  assign topNext    = nextMem[topIdx];
  assign topRc      = rcMem[topIdx];
  assign topRcValid = rcvBits[topIdx];
  assign topMask    = maskMem[topIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth    <= DW'(1);
      overflow <= 1'b0;
      rcvBits  <= '0;
      for (int s = 0; s < DEPTH; s++) begin
        nextMem[s] <= (s == 0) ? START_PC : '0;
        rcMem[s]   <= '0;
        maskMem[s] <= (s == 0) ? '1 : '0;
      end
    end else begin
      if (cmd.ovfSet) overflow <= 1'b1;
      if (cmd.pop) depth <= depth - DW'(1);
      else if (cmd.split) depth <= depth + DW'(2);
      for (int s = 0; s < DEPTH; s++) begin
        if ((cmd.retarget || cmd.split) && (int'(depth) == s + 1))
          nextMem[s] <= newNext;
        if (cmd.split && (int'(depth) == s)) begin
          nextMem[s] <= fallPc;
          rcMem[s]   <= rcPc;
          maskMem[s] <= fallSub;
          rcvBits[s] <= 1'b1;
        end
        if (cmd.split && (int'(depth) == s - 1)) begin
          nextMem[s] <= takenPc;
          rcMem[s]   <= rcPc;
          maskMem[s] <= takenSub;
          rcvBits[s] <= 1'b1;
        end
      end
    end
  end

  // R9: depth stays within the stack
  a_r9_depth_bounds: assert property (@(posedge clk) disable iff (!rstN)
    (int'(depth) >= 1) && (int'(depth) <= DEPTH));

  // R9: overflow flag is sticky
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R5: a split adds two entries
  a_r5_split_depth: assert property (@(posedge clk) disable iff (!rstN)
    cmd.split |=> (depth == $past(depth) + DW'(2)));

  // R6: a pop removes one entry
  a_r6_pop_depth: assert property (@(posedge clk) disable iff (!rstN)
    cmd.pop |=> (depth == $past(depth) - DW'(1)));

  // R10: the bottom entry is never popped
  a_r10_bottom_kept: assert property (@(posedge clk) disable iff (!rstN)
    (depth == DW'(1)) |-> !cmd.pop);

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_stack_pkg::*;
#(
  parameter int             THREADS  = 4,
  parameter int             DEPTH    = 8,
  parameter int             PCW      = 16,
  parameter logic [PCW-1:0] START_PC = '0,
  localparam int            DW       = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               brValid,
  input  logic [THREADS-1:0] brTaken,
  input  logic [PCW-1:0]     brTakenPc,
  input  logic [PCW-1:0]     brFallPc,
  input  logic [PCW-1:0]     brReconvPc,
  input  logic               stepValid,
  input  logic [PCW-1:0]     stepPc,
  output logic [PCW-1:0]     warpPc,
  output logic [THREADS-1:0] warpMask,
  output logic               issueOk,
  output logic [DW-1:0]      stackDepth,
  output logic               overflow
);

  stackCmd_t          cmd;
  logic [PCW-1:0]     newNext;
  logic [THREADS-1:0] takenSub;
  logic [THREADS-1:0] fallSub;
  logic [PCW-1:0]     topRc;
  logic               topRcValid;

  simt_stack_ctrl #(.THREADS(THREADS), .DEPTH(DEPTH), .PCW(PCW)) ctrl (
    .brValid(brValid), .brTaken(brTaken), .brTakenPc(brTakenPc),
    .brFallPc(brFallPc), .brReconvPc(brReconvPc), .stepValid(stepValid),
    .stepPc(stepPc), .topNext(warpPc), .topRc(topRc), .topRcValid(topRcValid),
    .topMask(warpMask), .depth(stackDepth), .cmd(cmd), .newNext(newNext),
    .takenSub(takenSub), .fallSub(fallSub), .issueOk(issueOk)
  );

  simt_stack_dp #(.THREADS(THREADS), .DEPTH(DEPTH), .PCW(PCW),
                  .START_PC(START_PC)) dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .newNext(newNext),
    .takenPc(brTakenPc), .fallPc(brFallPc), .rcPc(brReconvPc),
    .takenSub(takenSub), .fallSub(fallSub), .topNext(warpPc),
    .topRc(topRc), .topRcValid(topRcValid), .topMask(warpMask),
    .depth(stackDepth), .overflow(overflow)
  );

  // R2: a running warp never has an empty mask
  a_r2_mask_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    |warpMask);

  // R4: all active threads taken goes to the taken target, depth kept
  a_r4_uniform_taken: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && issueOk && ((brTaken & warpMask) == warpMask))
    |=> (warpPc == $past(brTakenPc)) && (stackDepth == $past(stackDepth)));

  // R4: no active thread taken goes to the fall-through target
  a_r4_uniform_fall: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && issueOk && ((brTaken & warpMask) == '0))
    |=> (warpPc == $past(brFallPc)) && (stackDepth == $past(stackDepth)));

  // R5: after a split the taken path is on top
  a_r5_taken_first: assert property (@(posedge clk) disable iff (!rstN)
    cmd.split |=> (warpPc == $past(brTakenPc))
                  && (warpMask == $past(brTaken & warpMask)));

  // R9: a refused split leaves the top untouched
  a_r9_refused_stable: assert property (@(posedge clk) disable iff (!rstN)
    cmd.ovfSet |=> $stable(warpPc) && $stable(warpMask) && $stable(stackDepth));

endmodule

// File: tb/simt_reconv_stack_test.sv
`timescale 1ns/1ps
module simt_reconv_stack_test;

  localparam int THREADS = 4;
  localparam int DEPTH   = 4;
  localparam int PCW     = 16;
  localparam int DW      = $clog2(DEPTH + 1);
  localparam logic [PCW-1:0] START = 16'd64;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               brValid = 1'b0;
  logic [THREADS-1:0] brTaken = '0;
  logic [PCW-1:0]     brTakenPc = '0;
  logic [PCW-1:0]     brFallPc = '0;
  logic [PCW-1:0]     brReconvPc = '0;
  logic               stepValid = 1'b0;
  logic [PCW-1:0]     stepPc = '0;
  logic [PCW-1:0]     warpPc;
  logic [THREADS-1:0] warpMask;
  logic               issueOk;
  logic [DW-1:0]      stackDepth;
  logic               overflow;

  int nChk = 0;
  int nBad = 0;

  always #4 clk = ~clk;

  simt_reconv_stack #(.THREADS(THREADS), .DEPTH(DEPTH), .PCW(PCW),
                      .START_PC(START)) uut (
    .clk(clk), .rstN(rstN), .brValid(brValid), .brTaken(brTaken),
    .brTakenPc(brTakenPc), .brFallPc(brFallPc), .brReconvPc(brReconvPc),
    .stepValid(stepValid), .stepPc(stepPc), .warpPc(warpPc),
    .warpMask(warpMask), .issueOk(issueOk), .stackDepth(stackDepth),
    .overflow(overflow)
  );

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expState(string tag, int pc, int mask, int d, int ovf, int ok);
    chk({tag, " pc"}, int'(warpPc), pc);
    chk({tag, " mask"}, int'(warpMask), mask);
    chk({tag, " depth"}, int'(stackDepth), d);
    chk({tag, " overflow"}, int'(overflow), ovf);
    chk({tag, " issueOk"}, int'(issueOk), ok);
  endtask

  task automatic doBranch(int tm, int t, int f, int r);
    brValid = 1'b1; brTaken = THREADS'(tm);
    brTakenPc = PCW'(t); brFallPc = PCW'(f); brReconvPc = PCW'(r);
    @(negedge clk);
    brValid = 1'b0; brTaken = '0;
  endtask

  task automatic doStep(int pc);
    stepValid = 1'b1; stepPc = PCW'(pc);
    @(negedge clk);
    stepValid = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expState("R1 reset", 64, 15, 1, 0, 1);

    doStep(10);
    expState("R3 step", 10, 15, 1, 0, 1);

    // Sweep every taken vector from a full mask (R2 R4 R5 R6 R10)
    for (int tm = 0; tm < 16; tm++) begin
      doBranch(tm, 100 + tm, 200 + tm, 300 + tm);
      if (tm == 0) begin
        expState("R4 none taken", 200, 15, 1, 0, 1);
      end else if (tm == 15) begin
        expState("R4 all taken", 115, 15, 1, 0, 1);
      end else begin
        expState("R5 split taken top", 100 + tm, tm, 3, 0, 1);
        doStep(300 + tm);
        expState("R6 taken at reconv", 300 + tm, tm, 3, 0, 0);
        @(negedge clk);
        expState("R6 fall path", 200 + tm, 15 ^ tm, 2, 0, 1);
        doStep(300 + tm);
        expState("R6 fall at reconv", 300 + tm, 15 ^ tm, 2, 0, 0);
        @(negedge clk);
        expState("R6 rejoined", 300 + tm, 15, 1, 0, 1);
        @(negedge clk);
        expState("R10 bottom kept", 300 + tm, 15, 1, 0, 1);
      end
      doStep(10);
    end

    // R7: events during a pop cycle are ignored
    doBranch(5, 500, 600, 700);
    expState("R5 split 0101", 500, 5, 3, 0, 1);
    doStep(700);
    expState("R7 pop pending", 700, 5, 3, 0, 0);
    brValid = 1'b1; brTaken = 4'b0001; brTakenPc = 16'd901;
    brFallPc = 16'd902; brReconvPc = 16'd903;
    stepValid = 1'b1; stepPc = 16'd904;
    @(negedge clk);
    brValid = 1'b0; stepValid = 1'b0; brTaken = '0;
    expState("R7 event ignored in pop", 600, 10, 2, 0, 1);
    doStep(700);
    @(negedge clk);
    expState("R7 unwound", 700, 15, 1, 0, 1);

    // R8: branch wins over step
    stepValid = 1'b1; stepPc = 16'd900;
    doBranch(15, 800, 850, 870);
    stepValid = 1'b0;
    expState("R8 branch priority", 800, 15, 1, 0, 1);

    // R11 and R9 at full depth
    doBranch(3, 110, 120, 130);
    expState("R5 split 0011", 110, 3, 3, 0, 1);
    doBranch(15, 140, 150, 160);
    expState("R11 inactive taken bits", 140, 3, 3, 0, 1);
    doBranch(12, 170, 180, 190);
    expState("R11 inactive only taken", 180, 3, 3, 0, 1);
    doBranch(13, 171, 181, 191);
    expState("R9 refused split", 180, 3, 3, 1, 1);
    doBranch(3, 210, 220, 230);
    expState("R9 uniform when full", 210, 3, 3, 1, 1);
    doStep(130);
    @(negedge clk);
    expState("R9 sticky after pop", 120, 12, 2, 1, 1);
    doStep(130);
    @(negedge clk);
    expState("R9 sticky unwound", 130, 15, 1, 1, 1);

    summary();
    $finish;
  end

endmodule